// File: doc/BRIEF.md
# Virtual Interrupt CPU Interface

This block presents virtual interrupts to a guest from a small array of list registers that a hypervisor fills in. Each list-register slot names a virtual interrupt ID, its priority, a two-bit life-cycle state, a flag that ties it to a physical interrupt, and the physical ID it stands for. The block drives its own registered virtual interrupt request line, separate from any physical IRQ line. This line is raised whenever some pending slot is more urgent than the guest's current virtual running priority.

The guest talks to the block through three strobes. An acknowledge returns the ID of the most urgent eligible slot, marks it active and takes its priority as the new running priority. An end-of-interrupt strobe performs only the priority drop and restores the running priority that held before the last acknowledge. A deactivate strobe, carrying a virtual ID, clears the active state of the matching slot. If that slot is tied to a physical interrupt, the block pulses a deactivate request carrying the stored physical ID toward the physical CPU interface, so the hypervisor does not have to step in.

Top module: `vgic_cpu_if`

## Requirements
- R1: A hypervisor write to slot `lr_idx_i` is visible on the slot's state readback on the cycle after the write strobe. State codes: 0 invalid, 1 pending, 2 active, 3 active+pending.
- R2: `virq_o` is a registered output. It goes high one cycle after the list registers first hold an eligible pending slot.
- R3: Among eligible slots, an acknowledge picks the lowest priority value. A tie goes to the lowest slot index.
- R4: An acknowledge with an eligible slot returns that slot's virtual ID on `ack_id_o` in the same cycle. On the next cycle the slot is active (code 2) and `rpr_o` equals the slot's priority.
- R5: An acknowledge with no eligible slot returns ID 1023 and changes neither any slot state nor `rpr_o`.
- R6: An end-of-interrupt strobe restores `rpr_o` to the value it had before the most recent unmatched acknowledge, or to 255 (idle) when none is left. It does not change any slot state.
- R7: A deactivate whose ID matches an active slot moves that slot to invalid. If the slot was active+pending, it moves to pending.
- R8: Deactivating a slot whose link flag is set raises `pdeact_o` for exactly one cycle, on the cycle after the strobe, with `pdeact_id_o` equal to the slot's physical ID.
- R9: A deactivate whose ID matches no active slot changes no slot and raises no `pdeact_o`.
- R10: A pending slot is eligible only when its priority value is strictly below `rpr_o`. With nothing eligible, `virq_o` is low.
- R11: After reset every slot is invalid, `virq_o` and `pdeact_o` are low, and `rpr_o` is 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lr_wr_i | input | 1 | Hypervisor write strobe for one slot |
| lr_idx_i | input | IDX_W | Slot index for the write |
| lr_vid_i | input | ID_W | Virtual ID to store |
| lr_prio_i | input | PRIO_W | Priority to store (lower value is more urgent) |
| lr_state_i | input | 2 | State code to store |
| lr_hw_i | input | 1 | Link-to-physical flag to store |
| lr_pid_i | input | ID_W | Physical ID to store |
| lr_rd_idx_i | input | IDX_W | Slot selected for state readback |
| lr_rd_state_o | output | 2 | State code of the selected slot |
| ack_i | input | 1 | Guest acknowledge strobe |
| ack_id_o | output | ID_W | Acknowledged ID, or 1023 when nothing is eligible |
| eoi_i | input | 1 | Guest priority-drop strobe |
| dir_i | input | 1 | Guest deactivate strobe |
| dir_id_i | input | ID_W | Virtual ID to deactivate |
| virq_o | output | 1 | Virtual interrupt request |
| rpr_o | output | PRIO_W | Virtual running priority, 255 when idle |
| pdeact_o | output | 1 | One-cycle physical deactivate request |
| pdeact_id_o | output | ID_W | Physical ID carried with the request |

## Verification
The checker assumes the hypervisor never stores virtual ID 1023 and never rewrites a slot in the cycle a guest strobe hits that slot. It also assumes the hypervisor does not turn an active slot back to pending, so the running-priority stack can never be full when an acknowledge finds a winner. Under these assumptions every acknowledge that returns a real ID must lower `rpr_o`, and every end-of-interrupt strobe must raise or keep it. The bench keeps within these limits by writing slots only in cycles with no guest strobe and by using IDs well below 1023. The one active+pending rewrite it makes comes after that slot's priority has already been dropped.

// File: rtl/vgic_pkg.sv
package vgic_pkg;
  typedef enum logic [1:0] {
    LR_INVALID  = 2'd0,
    LR_PENDING  = 2'd1,
    LR_ACTIVE   = 2'd2,
    LR_ACT_PEND = 2'd3
  } lr_state_e;

  localparam int unsigned SPURIOUS_ID = 1023;
  localparam int unsigned MIN_ID_W    = 10;
endpackage

// File: rtl/vgic_lr_bank.sv
module vgic_lr_bank
  import vgic_pkg::*;
#(
  parameter int unsigned NUM_LR = 4,
  parameter int unsigned ID_W   = 10,
  parameter int unsigned PRIO_W = 8,
  localparam int unsigned IDX_W = $clog2(NUM_LR)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_i,
  input  logic [IDX_W-1:0]               wr_idx_i,
  input  logic [ID_W-1:0]                wr_vid_i,
  input  logic [PRIO_W-1:0]              wr_prio_i,
  input  logic [1:0]                     wr_state_i,
  input  logic                           wr_hw_i,
  input  logic [ID_W-1:0]                wr_pid_i,
  input  logic [NUM_LR-1:0]              ack_set_i,
  input  logic [NUM_LR-1:0]              dir_clr_i,
  output logic [NUM_LR-1:0][ID_W-1:0]    vid_o,
  output logic [NUM_LR-1:0][PRIO_W-1:0]  prio_o,
  output logic [NUM_LR-1:0][1:0]         state_o,
  output logic [NUM_LR-1:0]              hw_o,
  output logic [NUM_LR-1:0][ID_W-1:0]    pid_o
);
  for (genvar i = 0; i < NUM_LR; i++) begin : g_lr
    lr_state_e st_q;
    logic      hit_wr;

    assign hit_wr = wr_i && (wr_idx_i == IDX_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_q      <= LR_INVALID;
        vid_o[i]  <= '0;
        prio_o[i] <= '1;
        hw_o[i]   <= 1'b0;
        pid_o[i]  <= '0;
      end else if (hit_wr) begin
        st_q      <= lr_state_e'(wr_state_i);
        vid_o[i]  <= wr_vid_i;
        prio_o[i] <= wr_prio_i;
        hw_o[i]   <= wr_hw_i;
        pid_o[i]  <= wr_pid_i;
      end else if (dir_clr_i[i]) begin
        // active+pending falls back to pending, plain active to invalid
        st_q <= (st_q == LR_ACT_PEND) ? LR_PENDING : LR_INVALID;
      end else if (ack_set_i[i]) begin
        st_q <= LR_ACTIVE;
      end
    end

    assign state_o[i] = st_q;
  end
endmodule

// File: rtl/vgic_pick.sv
module vgic_pick
  import vgic_pkg::*;
#(
  parameter int unsigned NUM_LR = 4,
  parameter int unsigned PRIO_W = 8,
  localparam int unsigned IDX_W = $clog2(NUM_LR)
) (
  input  logic [NUM_LR-1:0][1:0]        state_i,
  input  logic [NUM_LR-1:0][PRIO_W-1:0] prio_i,
  input  logic [PRIO_W-1:0]             rpr_i,
  output logic                          found_o,
  output logic [IDX_W-1:0]              idx_o
);
  always_comb begin
    logic              fnd;
    logic [IDX_W-1:0]  idx;
    logic [PRIO_W-1:0] best;
    fnd  = 1'b0;
    idx  = '0;
    best = '1;
    // strict compare keeps the lowest index on equal priority
    for (int i = 0; i < NUM_LR; i++) begin
      if (state_i[i] == LR_PENDING && prio_i[i] < rpr_i &&
          (!fnd || prio_i[i] < best)) begin
        fnd  = 1'b1;
        idx  = IDX_W'(i);
        best = prio_i[i];
      end
    end
    found_o = fnd;
    idx_o   = idx;
  end
endmodule

// File: rtl/vgic_match.sv
module vgic_match
  import vgic_pkg::*;
#(
  parameter int unsigned NUM_LR = 4,
  parameter int unsigned ID_W   = 10,
  localparam int unsigned IDX_W = $clog2(NUM_LR)
) (
  input  logic [NUM_LR-1:0][1:0]      state_i,
  input  logic [NUM_LR-1:0][ID_W-1:0] vid_i,
  input  logic [ID_W-1:0]             id_i,
  output logic                        hit_o,
  output logic [IDX_W-1:0]            idx_o
);
  always_comb begin
    logic             hit;
    logic [IDX_W-1:0] idx;
    hit = 1'b0;
    idx = '0;
    for (int i = 0; i < NUM_LR; i++) begin
      if (!hit && vid_i[i] == id_i &&
          (state_i[i] == LR_ACTIVE || state_i[i] == LR_ACT_PEND)) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
    end
    hit_o = hit;
    idx_o = idx;
  end
endmodule

// File: rtl/vgic_rpr_stack.sv
module vgic_rpr_stack #(
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned PRIO_W = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned SLOTS = 1 << CNT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [PRIO_W-1:0] push_prio_i,
  input  logic              pop_i,
  output logic [PRIO_W-1:0] rpr_o
);
  logic [PRIO_W-1:0] stk_q [SLOTS];
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  top;
  logic              empty;

  assign empty = (cnt_q == '0);
  assign top   = cnt_q - CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      for (int i = 0; i < SLOTS; i++) stk_q[i] <= '1;
    end else if (pop_i && !empty && push_i) begin
      stk_q[top] <= push_prio_i;
    end else if (pop_i && !empty) begin
      cnt_q <= top;
    end else if (push_i && cnt_q < CNT_W'(DEPTH)) begin
      stk_q[cnt_q] <= push_prio_i;
      cnt_q        <= cnt_q + CNT_W'(1);
    end
  end

  assign rpr_o = empty ? '1 : stk_q[top];
endmodule

// File: rtl/vgic_cpu_if.sv
module vgic_cpu_if
  import vgic_pkg::*;
#(
  parameter int unsigned NUM_LR = 4,
  parameter int unsigned ID_W   = 10,
  parameter int unsigned PRIO_W = 8,
  localparam int unsigned IDX_W = $clog2(NUM_LR)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lr_wr_i,
  input  logic [IDX_W-1:0]  lr_idx_i,
  input  logic [ID_W-1:0]   lr_vid_i,
  input  logic [PRIO_W-1:0] lr_prio_i,
  input  logic [1:0]        lr_state_i,
  input  logic              lr_hw_i,
  input  logic [ID_W-1:0]   lr_pid_i,
  input  logic [IDX_W-1:0]  lr_rd_idx_i,
  output logic [1:0]        lr_rd_state_o,
  input  logic              ack_i,
  output logic [ID_W-1:0]   ack_id_o,
  input  logic              eoi_i,
  input  logic              dir_i,
  input  logic [ID_W-1:0]   dir_id_i,
  output logic              virq_o,
  output logic [PRIO_W-1:0] rpr_o,
  output logic              pdeact_o,
  output logic [ID_W-1:0]   pdeact_id_o
);
  logic [NUM_LR-1:0][ID_W-1:0]   vid;
  logic [NUM_LR-1:0][PRIO_W-1:0] prio;
  logic [NUM_LR-1:0][1:0]        state;
  logic [NUM_LR-1:0]             hw;
  logic [NUM_LR-1:0][ID_W-1:0]   pid;
  logic [NUM_LR-1:0]             ack_set;
  logic [NUM_LR-1:0]             dir_clr;
  logic                          found;
  logic [IDX_W-1:0]              sel_idx;
  logic                          hit;
  logic [IDX_W-1:0]              hit_idx;
  logic                          ack_take;
  logic                          dir_take;

  vgic_lr_bank #(.NUM_LR(NUM_LR), .ID_W(ID_W), .PRIO_W(PRIO_W)) i_bank (
    .clk_i, .rst_ni,
    .wr_i(lr_wr_i), .wr_idx_i(lr_idx_i), .wr_vid_i(lr_vid_i),
    .wr_prio_i(lr_prio_i), .wr_state_i(lr_state_i), .wr_hw_i(lr_hw_i),
    .wr_pid_i(lr_pid_i), .ack_set_i(ack_set), .dir_clr_i(dir_clr),
    .vid_o(vid), .prio_o(prio), .state_o(state), .hw_o(hw), .pid_o(pid)
  );

  vgic_pick #(.NUM_LR(NUM_LR), .PRIO_W(PRIO_W)) i_pick (
    .state_i(state), .prio_i(prio), .rpr_i(rpr_o),
    .found_o(found), .idx_o(sel_idx)
  );

  vgic_match #(.NUM_LR(NUM_LR), .ID_W(ID_W)) i_match (
    .state_i(state), .vid_i(vid), .id_i(dir_id_i),
    .hit_o(hit), .idx_o(hit_idx)
  );

  vgic_rpr_stack #(.DEPTH(NUM_LR), .PRIO_W(PRIO_W)) i_rpr (
    .clk_i, .rst_ni,
    .push_i(ack_take), .push_prio_i(prio[sel_idx]),
    .pop_i(eoi_i), .rpr_o(rpr_o)
  );

  assign ack_take = ack_i && found;
  assign dir_take = dir_i && hit;

  for (genvar i = 0; i < NUM_LR; i++) begin : g_strobe
    assign ack_set[i] = ack_take && (sel_idx == IDX_W'(i));
    assign dir_clr[i] = dir_take && (hit_idx == IDX_W'(i));
  end

  assign ack_id_o      = found ? vid[sel_idx] : ID_W'(SPURIOUS_ID);
  assign lr_rd_state_o = state[lr_rd_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      virq_o      <= 1'b0;
      pdeact_o    <= 1'b0;
      pdeact_id_o <= '0;
    end else begin
      virq_o      <= found;
      pdeact_o    <= dir_take && hw[hit_idx];
      pdeact_id_o <= pid[hit_idx];
    end
  end
endmodule

// File: rtl/vgic_cpu_if_chk.sv
module vgic_cpu_if_chk #(
  parameter int unsigned ID_W   = 10,
  parameter int unsigned PRIO_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ack_i,
  input logic              eoi_i,
  input logic              dir_i,
  input logic [ID_W-1:0]   ack_id_o,
  input logic [PRIO_W-1:0] rpr_o,
  input logic              pdeact_o
);
  localparam logic [ID_W-1:0] SPUR = ID_W'(vgic_pkg::SPURIOUS_ID);

  AST_PDEACT_NEEDS_DIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pdeact_o |-> $past(dir_i)); // R8

  AST_SPURIOUS_HOLDS_RPR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && ack_id_o == SPUR && !eoi_i) |=> $stable(rpr_o)); // R5

  AST_ACK_LOWERS_RPR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && ack_id_o != SPUR && !eoi_i) |=> (rpr_o < $past(rpr_o))); // R4

  AST_EOI_RAISES_RPR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_i && !ack_i) |=> (rpr_o >= $past(rpr_o))); // R6
endmodule

bind vgic_cpu_if vgic_cpu_if_chk #(.ID_W(ID_W), .PRIO_W(PRIO_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ack_i(ack_i), .eoi_i(eoi_i),
  .dir_i(dir_i), .ack_id_o(ack_id_o), .rpr_o(rpr_o), .pdeact_o(pdeact_o)
);

// File: tb/test_vgic_cpu_if.sv
module test_vgic_cpu_if;
  localparam int unsigned NUM_LR = 4;
  localparam int unsigned ID_W   = 10;
  localparam int unsigned PRIO_W = 8;
  localparam int unsigned IDX_W  = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              lr_wr = 1'b0;
  logic [IDX_W-1:0]  lr_idx = '0;
  logic [ID_W-1:0]   lr_vid = '0;
  logic [PRIO_W-1:0] lr_prio = '0;
  logic [1:0]        lr_state = '0;
  logic              lr_hw = 1'b0;
  logic [ID_W-1:0]   lr_pid = '0;
  logic [IDX_W-1:0]  rd_idx = '0;
  logic [1:0]        rd_state;
  logic              ack = 1'b0;
  logic [ID_W-1:0]   ack_id;
  logic              eoi = 1'b0;
  logic              dir = 1'b0;
  logic [ID_W-1:0]   dir_id = '0;
  logic              virq;
  logic [PRIO_W-1:0] rpr;
  logic              pdeact;
  logic [ID_W-1:0]   pdeact_id;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  vgic_cpu_if #(.NUM_LR(NUM_LR), .ID_W(ID_W), .PRIO_W(PRIO_W)) i_vgic_cpu_if (
    .clk_i(clk), .rst_ni(rst_n),
    .lr_wr_i(lr_wr), .lr_idx_i(lr_idx), .lr_vid_i(lr_vid), .lr_prio_i(lr_prio),
    .lr_state_i(lr_state), .lr_hw_i(lr_hw), .lr_pid_i(lr_pid),
    .lr_rd_idx_i(rd_idx), .lr_rd_state_o(rd_state),
    .ack_i(ack), .ack_id_o(ack_id), .eoi_i(eoi), .dir_i(dir), .dir_id_i(dir_id),
    .virq_o(virq), .rpr_o(rpr), .pdeact_o(pdeact), .pdeact_id_o(pdeact_id)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  function automatic int slot_state(input int idx);
    rd_idx = IDX_W'(idx);
    return -1;
  endfunction

  task automatic read_state(input int idx, output int st);
    rd_idx = IDX_W'(idx);
    #1 st = int'(rd_state);
  endtask

  task automatic lr_write(input int idx, input int vid, input int prio,
                          input int st, input bit hw, input int pid);
    @(negedge clk);
    lr_wr = 1'b1; lr_idx = IDX_W'(idx); lr_vid = ID_W'(vid);
    lr_prio = PRIO_W'(prio); lr_state = 2'(st); lr_hw = hw; lr_pid = ID_W'(pid);
    @(negedge clk);
    lr_wr = 1'b0;
  endtask

  task automatic do_ack(output int id);
    @(negedge clk);
    ack = 1'b1;
    #1 id = int'(ack_id);
    @(negedge clk);
    ack = 1'b0;
  endtask

  task automatic do_eoi();
    @(negedge clk);
    eoi = 1'b1;
    @(negedge clk);
    eoi = 1'b0;
  endtask

  task automatic do_dir(input int id);
    @(negedge clk);
    dir = 1'b1; dir_id = ID_W'(id);
    @(negedge clk);
    dir = 1'b0;
  endtask

  task automatic t_reset();
    int st;
    check("R11 virq", int'(virq), 0);
    check("R11 rpr", int'(rpr), 255);
    check("R11 pdeact", int'(pdeact), 0);
    for (int i = 0; i < NUM_LR; i++) begin
      read_state(i, st);
      check("R11 slot state", st, 0);
    end
  endtask

  task automatic t_write_virq();
    int st;
    lr_write(0, 32, 8'h40, 1, 1'b1, 100);
    read_state(0, st);
    check("R1 write visible", st, 1);
    check("R2 virq not yet", int'(virq), 0);
    step();
    check("R2 virq raised", int'(virq), 1);
  endtask

  task automatic t_select();
    int id, st;
    lr_write(1, 40, 8'h20, 1, 1'b0, 0);
    lr_write(2, 41, 8'h20, 1, 1'b0, 0);
    step();
    do_ack(id);
    check("R3 tie lowest index", id, 40);
    check("R4 rpr takes prio", int'(rpr), 8'h20);
    read_state(1, st);
    check("R4 slot active", st, 2);
  endtask

  task automatic t_preempt();
    int id, st;
    step();
    check("R10 virq low when blocked", int'(virq), 0);
    do_ack(id);
    check("R5 spurious id", id, 1023);
    check("R5 rpr kept", int'(rpr), 8'h20);
    read_state(2, st);
    check("R5 slot2 unchanged", st, 1);
    read_state(0, st);
    check("R5 slot0 unchanged", st, 1);
  endtask

  task automatic t_nest();
    int id, st;
    lr_write(3, 50, 8'h10, 1, 1'b0, 0);
    step();
    check("R10 virq for more urgent", int'(virq), 1);
    do_ack(id);
    check("R4 nested ack id", id, 50);
    check("R4 nested rpr", int'(rpr), 8'h10);
    do_eoi();
    check("R6 drop to outer", int'(rpr), 8'h20);
    read_state(3, st);
    check("R6 slot stays active", st, 2);
    do_eoi();
    check("R6 drop to idle", int'(rpr), 255);
  endtask

  task automatic t_dir_plain();
    int st;
    do_dir(40);
    check("R7 no pdeact unlinked", int'(pdeact), 0);
    read_state(1, st);
    check("R7 active to invalid", st, 0);
  endtask

  task automatic t_dir_miss();
    int st;
    do_dir(77);
    check("R9 no pdeact", int'(pdeact), 0);
    read_state(3, st);
    check("R9 slot3 kept", st, 2);
    read_state(2, st);
    check("R9 slot2 kept", st, 1);
    read_state(0, st);
    check("R9 slot0 kept", st, 1);
  endtask

  task automatic t_hw();
    int id, st;
    do_ack(id);
    check("R3 lowest prio value", id, 41);
    do_eoi();
    do_ack(id);
    check("R3 next winner", id, 32);
    do_eoi();
    do_dir(32);
    check("R8 pdeact pulse", int'(pdeact), 1);
    check("R8 pdeact id", int'(pdeact_id), 100);
    read_state(0, st);
    check("R7 linked slot invalid", st, 0);
    step();
    check("R8 pulse one cycle", int'(pdeact), 0);
  endtask

  task automatic t_act_pend();
    int st;
    lr_write(2, 41, 8'h20, 3, 1'b0, 0);
    do_dir(41);
    read_state(2, st);
    check("R7 active+pending to pending", st, 1);
    check("R7 no pdeact", int'(pdeact), 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_write_virq();
    t_select();
    t_preempt();
    t_nest();
    t_dir_plain();
    t_dir_miss();
    t_hw();
    t_act_pend();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule